// File: doc/BRIEF.md
# Unified Modular Multiplier and Divider

This block computes one of three modular operations on N-bit operands against an odd modulus M. It can divide (X times the inverse of Y, mod M), form a Montgomery product (X*Y*2^-N mod M), or form an ordinary modular product (X*Y mod M). The caller places the operands, the modulus and an opcode on the inputs and pulses `start`. The unit runs an iterative sequence of halvings, doublings and modular additions or subtractions. It then pulses `done` for one cycle, with `result` and `err` valid in that cycle.

All three operations share one set of four N-bit working registers and four small modular arithmetic units: one halver, one subtractor and two adders. Division uses a binary form of the extended Euclidean algorithm, and each cycle performs one halving or one subtraction step. The Montgomery product scans the multiplier from its most significant bit. It adds a running copy of Y to the result, and that copy is halved modulo M on every step. The ordinary product scans the multiplier the same way but doubles the accumulator before each addition. Every intermediate value stays in [0, M), so no final correction pass is needed.

The controller has three states. `ST_IDLE` waits for `start`. `ST_RUN` performs one step per cycle. `ST_FINISH` presents the result for one cycle.

The transitions are:
- `ST_IDLE` goes to `ST_RUN` on `start` with a defined opcode.
- `ST_IDLE` goes to `ST_FINISH` on `start` with the reserved opcode.
- `ST_RUN` goes to `ST_FINISH` when the divider's working value reaches zero, or when the last multiplier bit has been consumed.
- `ST_FINISH` always returns to `ST_IDLE`.

Top module: `modmuldiv_unit`

## Requirements
- R1: With opcode 2'b00 (division), for gcd(Y, M) = 1, the unit returns r in [0, M) with r*Y ≡ X (mod M), and `err` low.
- R2: With opcode 2'b00, when gcd(Y, M) ≠ 1 (including Y = 0), the unit returns `err` high and `result` equal to 0.
- R3: With opcode 2'b01 (Montgomery), the unit returns the r in [0, M) with r*2^N ≡ X*Y (mod M).
- R4: A division completes with `done` no later than 4N+2 rising edges after the edge that samples `start`.
- R5: With opcode 2'b10 (ordinary), the unit returns X*Y mod M.
- R6: For both multiply opcodes, `done` is high after exactly the N-th rising edge following the edge that samples `start`. `done` is high for exactly one cycle, and `busy` and `done` are never high together.
- R7: Opcode 2'b11 is reserved. It produces `done` with `err` high right after the edge that samples `start`, and `result` is 0.
- R8: `start` is ignored while `busy` is high: the running operation's result is unaffected.
- R9: After reset, `busy`, `done`, `err` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; sampled only when idle |
| opcode | input | 2 | 00 divide, 01 Montgomery, 10 ordinary multiply, 11 reserved |
| op_x | input | N | Dividend or multiplier X, less than M |
| op_y | input | N | Divisor or multiplicand Y, less than M |
| modulus | input | N | Odd modulus M, greater than 1 |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse; result and err are valid |
| err | output | 1 | The operation produced no result |
| result | output | N | Reduced result in [0, M) |

## Verification
The assertions rely on the following input conditions:
- `modulus` is odd, at least 3, and held steady from `start` until `done`.
- `op_x` and `op_y` are already reduced below M.
- `start` is raised only while the unit is idle, except for the deliberate mid-run pulse.

Under these conditions the result-range and latency properties are meaningful. The random stimulus builds each modulus by forcing bit 0 to one and clamping it to at least 3, and draws each operand as a remainder modulo that modulus. The directed cases stay within the same limits: the largest odd modulus, operands of zero and of M-1, divisors that share a factor with M, and a zero divisor.

// File: rtl/modmuldiv_pkg.sv
package modmuldiv_pkg;
    typedef enum logic [1:0] {
        OP_DIV  = 2'b00,
        OP_MONT = 2'b01,
        OP_MUL  = 2'b10,
        OP_RSVD = 2'b11
    } opcode_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FINISH
    } state_t;
endpackage

// File: rtl/modmuldiv_halve.sv
// Halves a residue modulo an odd modulus: adds M first when the value is odd.
module modmuldiv_halve #(
    parameter int N = 16
) (
    input  logic [N-1:0] val,
    input  logic [N-1:0] m,
    output logic [N-1:0] half
);
    logic [N:0] widened;

    always_comb begin
        widened = {1'b0, val} + (val[0] ? {1'b0, m} : '0);
        half    = widened[N:1];
    end
endmodule

// File: rtl/modmuldiv_addsub.sv
// Modular add or subtract of two residues in [0, M); the variant is a parameter.
module modmuldiv_addsub #(
    parameter int N        = 16,
    parameter bit SUBTRACT = 1'b0
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic [N-1:0] m,
    output logic [N-1:0] y
);
    logic [N:0] raw;

    generate
        if (SUBTRACT) begin : g_sub
            always_comb begin
                raw = {1'b0, a} - {1'b0, b};
                y   = raw[N] ? (raw[N-1:0] + m) : raw[N-1:0];
            end
        end else begin : g_add
            always_comb begin
                raw = {1'b0, a} + {1'b0, b};
                y   = (raw >= {1'b0, m}) ? (raw[N-1:0] - m) : raw[N-1:0];
            end
        end
    endgenerate
endmodule

// File: rtl/modmuldiv_unit.sv
module modmuldiv_unit
    import modmuldiv_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [1:0]   opcode,
    input  logic [N-1:0] op_x,
    input  logic [N-1:0] op_y,
    input  logic [N-1:0] modulus,
    output logic         busy,
    output logic         done,
    output logic         err,
    output logic [N-1:0] result
);
    localparam int CW = (N > 1) ? $clog2(N) : 1;

    state_t         state_q, state_d;
    opcode_t        op_q;
    logic [N-1:0]   ra, rb, ru, rv;
    logic [CW-1:0]  cnt;
    logic [N-1:0]   res_q;
    logic           err_q;

    // shared arithmetic
    logic [N-1:0]   hv_in, hv_out;
    logic [N-1:0]   sub_a, sub_b, sub_out;
    logic [N-1:0]   add0_b, add0_out, add1_out, acc_next;
    logic           a_ge_b, div_end, mul_end;

    always_comb begin
        a_ge_b = (ra >= rb);
        hv_in  = (op_q == OP_DIV && !ra[0]) ? ru : rv;
        sub_a  = a_ge_b ? ru : rv;
        sub_b  = a_ge_b ? rv : ru;
        add0_b = (op_q == OP_MONT) ? hv_out : ru;
    end

    modmuldiv_halve  #(.N(N))                  halve_i (.val(hv_in), .m(modulus), .half(hv_out));
    modmuldiv_addsub #(.N(N), .SUBTRACT(1'b1)) sub_i   (.a(sub_a), .b(sub_b), .m(modulus), .y(sub_out));
    modmuldiv_addsub #(.N(N), .SUBTRACT(1'b0)) add0_i  (.a(ru), .b(add0_b), .m(modulus), .y(add0_out));
    modmuldiv_addsub #(.N(N), .SUBTRACT(1'b0)) add1_i  (.a(add0_out), .b(rv), .m(modulus), .y(add1_out));

    always_comb begin
        if (op_q == OP_MONT) acc_next = ra[N-1] ? add0_out : ru;
        else                 acc_next = ra[N-1] ? add1_out : add0_out;
        div_end = (op_q == OP_DIV) && (ra == '0);
        mul_end = (op_q != OP_DIV) && (cnt == '0);
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = (opcode_t'(opcode) == OP_RSVD) ? ST_FINISH : ST_RUN;
            ST_RUN:    if (div_end || mul_end) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= OP_DIV;
            ra    <= '0;
            rb    <= '0;
            ru    <= '0;
            rv    <= '0;
            cnt   <= '0;
            res_q <= '0;
            err_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    op_q  <= opcode_t'(opcode);
                    cnt   <= CW'(N - 1);
                    res_q <= '0;
                    err_q <= (opcode_t'(opcode) == OP_RSVD);
                    if (opcode_t'(opcode) == OP_DIV) begin
                        ra <= op_y;
                        rb <= modulus;
                        ru <= op_x;
                        rv <= '0;
                    end else begin
                        ra <= op_x;
                        rb <= '0;
                        ru <= '0;
                        rv <= op_y;
                    end
                end
                ST_RUN: begin
                    if (op_q == OP_DIV) begin
                        if (div_end) begin
                            err_q <= (rb != N'(1));
                            res_q <= (rb == N'(1)) ? rv : '0;
                        end else if (!ra[0]) begin
                            ra <= ra >> 1;
                            ru <= hv_out;
                        end else if (!rb[0]) begin
                            rb <= rb >> 1;
                            rv <= hv_out;
                        end else if (a_ge_b) begin
                            ra <= ra - rb;
                            ru <= sub_out;
                        end else begin
                            rb <= rb - ra;
                            rv <= sub_out;
                        end
                    end else begin
                        ru  <= acc_next;
                        ra  <= ra << 1;
                        cnt <= cnt - 1'b1;
                        if (op_q == OP_MONT) rv <= hv_out;
                        if (mul_end) res_q <= acc_next;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy   = (state_q == ST_RUN);
        done   = (state_q == ST_FINISH);
        err    = done && err_q;
        result = done ? res_q : '0;
    end
endmodule

// File: rtl/modmuldiv_chk.sv
module modmuldiv_chk #(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [1:0]   opcode,
    input logic [N-1:0] modulus,
    input logic         busy,
    input logic         done,
    input logic         err,
    input logic [N-1:0] result
);
    int         cyc;
    logic [1:0] opc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc <= 0;
            opc <= 2'b00;
        end else if (start && !busy && !done) begin
            cyc <= 0;
            opc <= opcode;
        end else if (busy) begin
            cyc <= cyc + 1;
        end
    end

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_done_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_mult_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (opc == 2'b01 || opc == 2'b10)) |-> (cyc == N));

    assert_div_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && opc == 2'b00) |-> (cyc <= 4*N + 2));

    assert_reserved_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done && opcode == 2'b11) |=> (done && err));

    assert_result_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (result < modulus));

    assert_err_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (result == '0));
endmodule

bind modmuldiv_unit modmuldiv_chk #(.N(N)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .modulus(modulus),
    .busy(busy), .done(done), .err(err), .result(result)
);

// File: tb/modmuldiv_unit_tb.sv
module modmuldiv_unit_tb_top;
    localparam int N  = 16;
    localparam int WD = 8*N + 20;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   opcode = 2'b00;
    logic [N-1:0] op_x = '0, op_y = '0, modulus = 16'd3;
    logic         busy, done, err;
    logic [N-1:0] result;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    modmuldiv_unit #(.N(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .op_x(op_x), .op_y(op_y), .modulus(modulus),
        .busy(busy), .done(done), .err(err), .result(result)
    );

    function automatic longint gcd_f(longint a, longint b);
        while (b != 0) begin
            longint t = a % b;
            a = b;
            b = t;
        end
        return a;
    endfunction

    function automatic longint mont_f(longint x, longint y, longint m);
        longint t = (x * y) % m;
        for (int i = 0; i < N; i++) t = (t % 2 == 1) ? (t + m) / 2 : t / 2;
        return t;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] op, input logic [N-1:0] x, input logic [N-1:0] y,
                          input logic [N-1:0] m, output logic [N-1:0] r, output logic e,
                          output int lat);
        @(negedge clk);
        opcode = op; op_x = x; op_y = y; modulus = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < WD) begin
            @(negedge clk);
            lat++;
        end
        r = result;
        e = err;
        chk(done == 1'b1, "R4 done seen", lat, 0);
        @(negedge clk);
        chk(done == 1'b0, "R6 done one cycle", done, 0);
    endtask

    task automatic check_op(input logic [1:0] op, input logic [N-1:0] x, input logic [N-1:0] y,
                            input logic [N-1:0] m);
        logic [N-1:0] r;
        logic e;
        int lat;
        longint xl = x, yl = y, ml = m, rl;
        run_op(op, x, y, m, r, e, lat);
        rl = r;
        case (op)
            2'b00: begin
                if (gcd_f(yl, ml) != 1) begin
                    chk(e == 1'b1 && r == '0, "R2 non-invertible", rl, 0);
                end else begin
                    chk(e == 1'b0 && rl < ml && (rl * yl) % ml == xl, "R1 division", rl, xl);
                end
                chk(lat - 1 <= 4*N + 2, "R4 division bound", lat - 1, 4*N + 2);
            end
            2'b01: begin
                chk(e == 1'b0 && rl == mont_f(xl, yl, ml), "R3 montgomery", rl, mont_f(xl, yl, ml));
                chk(lat - 1 == N, "R6 montgomery latency", lat - 1, N);
            end
            2'b10: begin
                chk(e == 1'b0 && rl == (xl * yl) % ml, "R5 ordinary", rl, (xl * yl) % ml);
                chk(lat - 1 == N, "R6 ordinary latency", lat - 1, N);
            end
            default: begin
                chk(e == 1'b1 && r == '0, "R7 reserved err", rl, 0);
                chk(lat == 1, "R7 reserved latency", lat, 1);
            end
        endcase
    endtask

    initial begin
        #2000000;
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [N-1:0] r;
        logic e;
        int lat;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && err == 1'b0 && result == '0, "R9 reset state", result, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R9 idle after reset", busy, 0);

        // directed corners
        check_op(2'b00, 16'd7, 16'd0, 16'd15);        // R2 zero divisor
        check_op(2'b00, 16'd4, 16'd5, 16'd15);        // R2 shared factor
        check_op(2'b00, 16'd0, 16'd1, 16'd3);         // R1 zero dividend
        check_op(2'b00, 16'd65534, 16'd65533, 16'd65535);
        check_op(2'b01, 16'd65534, 16'd65534, 16'd65535);
        check_op(2'b10, 16'd65534, 16'd65534, 16'd65535);
        check_op(2'b01, 16'd0, 16'd5, 16'd7);
        check_op(2'b10, 16'd2, 16'd2, 16'd3);
        check_op(2'b11, 16'd1, 16'd1, 16'd3);         // R7

        // R8: start pulse during a run is ignored
        @(negedge clk);
        opcode = 2'b10; op_x = 16'd1234; op_y = 16'd4321; modulus = 16'd9999; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        opcode = 2'b00; op_x = 16'd1; op_y = 16'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        op_x = 16'd1234; op_y = 16'd4321;
        lat = 0;
        while (!done && lat < WD) begin
            @(negedge clk);
            lat++;
        end
        r = result;
        e = err;
        chk(e == 1'b0 && r == N'((64'd1234 * 64'd4321) % 64'd9999), "R8 start ignored while busy",
            r, (64'd1234 * 64'd4321) % 64'd9999);
        @(negedge clk);

        // constrained random
        for (int i = 0; i < 120; i++) begin
            logic [N-1:0] m, x, y;
            m = N'($urandom) | N'(1);
            if (m < 3) m = 16'd3;
            x = N'($urandom % m);
            y = N'($urandom % m);
            check_op(2'(i % 3), x, y, m);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule